// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block produces the open-drain drive pattern of an I2C master's SCL and SDA lines. It runs from a functional clock and five timing fields: a prescale exponent, an SCL low count, an SCL high count, an edge (setup/hold) count and a data-valid count. Every count is measured in units of 2^prescale functional clock cycles. A requester issues one command at a time through a valid/ready handshake: START (which becomes a repeated START when the bus is already held), one data bit, or STOP. Framing, acknowledge handling, addressing and arbitration sit above this block.

Each pad is modelled as an output enable: a 1 pulls the line low and a 0 releases it. The block reads back the filtered SCL level. It does not begin the high-phase count until that level is seen high, so a slave that stretches the clock, and any latency on the input path, lengthens the high phase. After a START or a bit the block keeps SCL pulled low and waits for the next command. After a STOP it releases the bus and returns to idle.

Timing fields that fall below their minimums are clamped to legal values. The data-valid count is also kept at or below the low count minus the SDA input latency minus one, so SDA is settled before SCL rises. An error output flags any active clamp. The prescale value is expected to stay constant while a transfer is in progress, including when a faster set of counts is swapped in.

Top module: `i2c_bit_timer`

## Requirements
- R1: During and right after reset, scl_oe and sda_oe are 0 (both lines released) and cmd_ready is 1.
- R2: One unit is 2^cfg_pre_exp functional clock cycles, and every low, high, edge and data-valid count below is multiplied by it.
- R3: A START (cmd_kind 0) accepted in idle waits until scl_in is high. sda_oe then rises 1 + edge*unit cycles after acceptance, and scl_oe rises a further edge*unit cycles later. The block then holds the bus with cmd_ready high.
- R4: A bit command (cmd_kind 1) accepted while the bus is held changes sda_oe to the inverse of cmd_bit exactly dv*unit cycles after acceptance. It releases SCL (scl_oe to 0) exactly low*unit cycles after acceptance.
- R5: The high phase is counted only from the first cycle scl_in is high. scl_oe is pulled again high*unit + 1 + S cycles after SCL was released, where S is the number of extra cycles the line is held low by a slave.
- R6: sda_oe changes while scl_oe is 0 only at the SDA edge of a START, repeated START or STOP, and at most once per command.
- R7: A START accepted while the bus is held is a repeated START. SDA is released after dv*unit and SCL after low*unit. Once scl_in is high, sda_oe rises after edge*unit and scl_oe rises after another edge*unit, and the bus is held again.
- R8: A STOP (cmd_kind 2) accepted while the bus is held pulls SDA after dv*unit and releases SCL after low*unit. It releases SDA edge*unit cycles after scl_in is seen high and returns to idle with both lines released.
- R9: The effective counts are low = max(low,3), high = max(high,1), edge = max(edge,2) and dv clamped to the range 1 to low-2 (with SDA latency 1). cfg_err is 1 exactly when any of these clamps changes a programmed value.
- R10: A bit, a STOP or code 3 accepted in idle, and code 3 accepted while the bus is held, are consumed with no effect on scl_oe, sda_oe or cmd_ready.
- R11: cmd_ready is 1 only in idle or while holding the bus. While it waits for a command after a START or a bit, SCL stays pulled low and SDA keeps its value. The bus leaves the held state only on an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pre_exp | input | PRE_W | Prescale exponent; unit = 2^value cycles |
| cfg_low_cnt | input | CNT_W | SCL low count in units |
| cfg_high_cnt | input | CNT_W | SCL high count in units |
| cfg_edge_cnt | input | CNT_W | Setup/hold count for START and STOP in units |
| cfg_dv_cnt | input | CNT_W | Delay from SCL low to SDA update in units |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 0 START, 1 bit, 2 STOP, 3 no operation |
| cmd_bit | input | 1 | Data bit for a bit command |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| scl_in | input | 1 | Filtered SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_err | output | 1 | A timing field was clamped |

## Verification
Every result is due a fixed number of cycles after the acceptance edge. The SDA data update is due dv*unit cycles later and the SCL release low*unit cycles later. The START and STOP SDA edges are due one cycle plus edge*unit after SCL reads high, and the next SCL pull is due high*unit + 1 + stretch after the release. The bench samples on falling clock edges and numbers each falling edge from the acceptance edge. It records the first cycle each line changes and compares that cycle with the value computed from the clamped counts. cfg_err is combinational and is checked shortly after each new configuration is applied.

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 3,
  parameter int SDA_LAT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_pre_exp,
  input  logic [CNT_W-1:0] cfg_low_cnt,
  input  logic [CNT_W-1:0] cfg_high_cnt,
  input  logic [CNT_W-1:0] cfg_edge_cnt,
  input  logic [CNT_W-1:0] cfg_dv_cnt,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_bit,
  output logic             cmd_ready,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             cfg_err
);

  localparam int PS_W   = (1 << PRE_W) - 1;
  localparam int LO_MIN = (SDA_LAT + 2 > 3) ? SDA_LAT + 2 : 3;
  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_BIT   = 2'd1;
  localparam logic [1:0] K_STOP  = 2'd2;
  localparam logic [1:0] K_NOP   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_LOW, S_RISE, S_HIGH, S_SU, S_HD
  } st_t;

  st_t              st;
  logic [1:0]       op;
  logic             tgt;
  logic [PS_W-1:0]  ps, ps_lim;
  logic [PS_W:0]    unit;
  logic [CNT_W-1:0] cnt, len, lo_e, hi_e, sh_e, dv_e, dv_max;
  logic             lo_bad, hi_bad, sh_bad, dv_small, dv_big;
  logic             tick, last, go;

  assign unit   = (PS_W + 1)'(1) << cfg_pre_exp;
  assign ps_lim = PS_W'(unit - 1'b1);

  assign lo_bad   = cfg_low_cnt < CNT_W'(LO_MIN);
  assign hi_bad   = cfg_high_cnt == '0;
  assign sh_bad   = cfg_edge_cnt < CNT_W'(2);
  assign lo_e     = lo_bad ? CNT_W'(LO_MIN) : cfg_low_cnt;
  assign hi_e     = hi_bad ? CNT_W'(1) : cfg_high_cnt;
  assign sh_e     = sh_bad ? CNT_W'(2) : cfg_edge_cnt;
  assign dv_max   = lo_e - CNT_W'(SDA_LAT + 1);
  assign dv_small = cfg_dv_cnt == '0;
  assign dv_big   = cfg_dv_cnt > dv_max;
  assign dv_e     = dv_small ? CNT_W'(1) : (dv_big ? dv_max : cfg_dv_cnt);
  assign cfg_err  = lo_bad | hi_bad | sh_bad | dv_small | dv_big;

  always_comb begin
    case (st)
      S_LOW:   len = lo_e;
      S_HIGH:  len = hi_e;
      default: len = sh_e;
    endcase
  end

  assign tick      = ps == ps_lim;
  assign last      = tick && (cnt == len - 1'b1);
  assign cmd_ready = (st == S_IDLE) || (st == S_HOLD);
  assign scl_oe    = (st == S_HOLD) || (st == S_LOW);
  assign go        = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= K_BIT;
      tgt    <= 1'b0;
      ps     <= '0;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (tick) begin
        ps  <= '0;
        cnt <= cnt + 1'b1;
      end else begin
        ps <= ps + 1'b1;
      end
      case (st)
        S_IDLE: begin
          ps  <= '0;
          cnt <= '0;
          if (go && cmd_kind == K_START) begin
            st <= S_RISE;
            op <= K_START;
          end
        end
        S_HOLD: begin
          ps  <= '0;
          cnt <= '0;
          if (go && cmd_kind != K_NOP) begin
            st  <= S_LOW;
            op  <= cmd_kind;
            tgt <= (cmd_kind == K_STOP) | ((cmd_kind == K_BIT) & ~cmd_bit);
          end
        end
        S_LOW: begin
          if (tick && cnt == dv_e - 1'b1) sda_oe <= tgt;
          if (last) begin
            st  <= S_RISE;
            ps  <= '0;
            cnt <= '0;
          end
        end
        S_RISE: begin
          ps  <= '0;
          cnt <= '0;
          if (scl_in) st <= (op == K_BIT) ? S_HIGH : S_SU;
        end
        S_HIGH: begin
          if (last) begin
            st  <= S_HOLD;
            ps  <= '0;
            cnt <= '0;
          end
        end
        S_SU: begin
          if (last) begin
            ps  <= '0;
            cnt <= '0;
            if (op == K_START) begin
              sda_oe <= 1'b1;
              st     <= S_HD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_IDLE;
            end
          end
        end
        S_HD: begin
          if (last) begin
            st  <= S_HOLD;
            ps  <= '0;
            cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       st,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             scl_in,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             cfg_err,
  input logic [CNT_W-1:0] cfg_low_cnt,
  input logic [CNT_W-1:0] cfg_high_cnt,
  input logic [CNT_W-1:0] cfg_edge_cnt,
  input logic [CNT_W-1:0] cfg_dv_cnt
);

  localparam logic [2:0] C_HOLD = 3'd1;
  localparam logic [2:0] C_RISE = 3'd3;
  localparam logic [2:0] C_SU   = 3'd5;

  assert_sda_quiet_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> ($past(st) == C_SU));

  assert_wait_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RISE && !scl_in) |=> (st == C_RISE));

  assert_hold_leaves_on_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_HOLD && st != C_HOLD) |-> $past(cmd_valid && cmd_ready));

  assert_idle_bus_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !scl_oe) |-> !sda_oe);

  assert_clamp_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_low_cnt < CNT_W'(3) || cfg_high_cnt == '0 || cfg_edge_cnt < CNT_W'(2) ||
     cfg_dv_cnt == '0) |-> cfg_err);

endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_err(cfg_err),
  .cfg_low_cnt(cfg_low_cnt), .cfg_high_cnt(cfg_high_cnt),
  .cfg_edge_cnt(cfg_edge_cnt), .cfg_dv_cnt(cfg_dv_cnt)
);

// File: tb/i2c_bit_timer_tb.sv
module i2c_bit_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_pre_exp = '0;
  logic [7:0] cfg_low_cnt = 8'd11, cfg_high_cnt = 8'd5, cfg_edge_cnt = 8'd4, cfg_dv_cnt = 8'd2;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic       cmd_bit = 1'b0;
  logic       cmd_ready, scl_oe, sda_oe, cfg_err, scl_in;
  logic       hold = 1'b0;

  int nchk = 0, nfail = 0, cyc = 0;
  int eU, eLo, eHi, eSh, eDv;

  assign scl_in = ~scl_oe & ~hold;

  always #2.5 clk = ~clk;

  i2c_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pre_exp(cfg_pre_exp), .cfg_low_cnt(cfg_low_cnt),
    .cfg_high_cnt(cfg_high_cnt), .cfg_edge_cnt(cfg_edge_cnt), .cfg_dv_cnt(cfg_dv_cnt),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
    .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_err(cfg_err)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_dv(input int lo, input int dv);
    if (dv < 1) return 1;
    if (dv > lo - 2) return lo - 2;
    return dv;
  endfunction

  task automatic set_cfg(input int p, input int lo, input int hi, input int sh, input int dv);
    logic exp_err;
    @(negedge clk);
    cfg_pre_exp  = 3'(p);
    cfg_low_cnt  = 8'(lo);
    cfg_high_cnt = 8'(hi);
    cfg_edge_cnt = 8'(sh);
    cfg_dv_cnt   = 8'(dv);
    eU  = 1 << p;
    eLo = (lo < 3) ? 3 : lo;
    eHi = (hi < 1) ? 1 : hi;
    eSh = (sh < 2) ? 2 : sh;
    eDv = clamp_dv(eLo, dv);
    exp_err = (lo < 3) || (hi < 1) || (sh < 2) || (dv < 1) || (dv > eLo - 2);
    #1;
    chk(cfg_err == exp_err, "R9 cfg_err", int'(cfg_err), int'(exp_err));
  endtask

  // kind: 0 START, 1 bit, 2 STOP; S = extra stretch cycles after SCL release
  task automatic run(input logic [1:0] kind, input logic b, input int S);
    logic old_sda, old_scl, prev_sda, prev_scl;
    int t_lo, t_rel, t_hi, n_hi, t_fall, rem;
    int x_lo, x_rel, x_hi, x_nhi, x_fall;
    string rq;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 ready before cmd", int'(cmd_ready), 1);
    old_sda = sda_oe;
    old_scl = scl_oe;
    cmd_valid = 1'b1;
    cmd_kind  = kind;
    cmd_bit   = b;
    hold      = (S > 0);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t_lo = -1; t_rel = -1; t_hi = -1; n_hi = 0; t_fall = -1; rem = S;
    prev_sda = old_sda;
    prev_scl = old_scl;
    for (int c = 0; c < 20000; c++) begin
      if (c > 0) @(negedge clk);
      if (sda_oe != prev_sda) begin
        if (scl_oe) begin
          if (t_lo < 0) t_lo = c;
        end else begin
          n_hi++;
          if (t_hi < 0) t_hi = c;
        end
      end
      if (prev_scl && !scl_oe && t_rel < 0) t_rel = c;
      if (!prev_scl && scl_oe && t_fall < 0) t_fall = c;
      if (t_rel >= 0 && c > t_rel && rem > 0) begin
        rem--;
        if (rem == 0) hold = 1'b0;
      end
      prev_sda = sda_oe;
      prev_scl = scl_oe;
      if (c > 0 && cmd_ready) break;
    end
    hold = 1'b0;
    if (kind == 2'd1) begin
      rq = "R4";
      x_lo = (old_sda != ~b) ? eDv * eU : -1;
      x_rel = eLo * eU; x_hi = -1; x_nhi = 0;
      x_fall = eLo * eU + 1 + S + eHi * eU;
      chk(t_fall == x_fall, "R5 high phase", t_fall, x_fall);
      chk(sda_oe == ~b, "R4 sda value", int'(sda_oe), int'(~b));
    end else if (kind == 2'd2) begin
      rq = "R8";
      x_lo = !old_sda ? eDv * eU : -1;
      x_rel = eLo * eU; x_hi = eLo * eU + 1 + S + eSh * eU; x_nhi = 1; x_fall = -1;
    end else if (!old_scl) begin
      rq = "R3";
      x_lo = -1; x_rel = -1; x_hi = 1 + eSh * eU; x_nhi = 1; x_fall = 1 + 2 * eSh * eU;
    end else begin
      rq = "R7";
      x_lo = old_sda ? eDv * eU : -1;
      x_rel = eLo * eU; x_hi = eLo * eU + 1 + S + eSh * eU; x_nhi = 1;
      x_fall = x_hi + eSh * eU;
    end
    chk(t_lo == x_lo, {rq, " sda change in low"}, t_lo, x_lo);
    chk(t_rel == x_rel, {rq, " scl release"}, t_rel, x_rel);
    chk(t_hi == x_hi, {rq, " sda edge in high"}, t_hi, x_hi);
    chk(n_hi == x_nhi, "R6 sda changes while scl high", n_hi, x_nhi);
    chk(t_fall == x_fall, {rq, " scl pull"}, t_fall, x_fall);
    chk(scl_oe == (kind != 2'd2), {rq, " final scl"}, int'(scl_oe), int'(kind != 2'd2));
    if (kind != 2'd1)
      chk(sda_oe == (kind == 2'd0), {rq, " final sda"}, int'(sda_oe), int'(kind == 2'd0));
  endtask

  task automatic ignored(input logic [1:0] kind);
    logic s0, d0;
    @(negedge clk);
    s0 = scl_oe;
    d0 = sda_oe;
    cmd_valid = 1'b1;
    cmd_kind  = kind;
    cmd_bit   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk(scl_oe == s0 && sda_oe == d0 && cmd_ready, "R10 no effect",
          int'({scl_oe, sda_oe, cmd_ready}), int'({s0, d0, 1'b1}));
      @(negedge clk);
    end
  endtask

  task automatic held_wait();
    logic d0;
    d0 = sda_oe;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(scl_oe && sda_oe == d0 && cmd_ready, "R11 bus held",
          int'({scl_oe, sda_oe}), int'({1'b1, d0}));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(scl_oe == 1'b0 && sda_oe == 1'b0 && cmd_ready, "R1 reset",
        int'({scl_oe, sda_oe, cmd_ready}), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0 && cmd_ready, "R1 after reset",
        int'({scl_oe, sda_oe, cmd_ready}), 1);

    // 8 MHz / 400 kbps style counts
    set_cfg(0, 11, 5, 4, 2);
    ignored(2'd1);
    ignored(2'd2);
    ignored(2'd3);
    run(2'd0, 1'b0, 0);
    held_wait();
    run(2'd1, 1'b0, 0);
    run(2'd1, 1'b1, 2);
    ignored(2'd3);
    run(2'd1, 1'b1, 0);
    run(2'd0, 1'b0, 1);
    run(2'd1, 1'b0, 0);
    run(2'd2, 1'b0, 0);

    // 1 Mbps counts, minimum legal values
    set_cfg(0, 3, 1, 2, 1);
    run(2'd0, 1'b0, 0);
    run(2'd1, 1'b0, 3);
    run(2'd2, 1'b0, 0);

    // R2: prescaled unit of 4 cycles
    set_cfg(2, 6, 4, 3, 4);
    run(2'd0, 1'b0, 0);
    run(2'd1, 1'b1, 0);
    run(2'd1, 1'b0, 0);
    run(2'd2, 1'b0, 0);

    // R9 clamps: everything below minimum, then dv above its bound
    set_cfg(0, 0, 0, 0, 0);
    run(2'd0, 1'b0, 0);
    run(2'd1, 1'b0, 0);
    run(2'd2, 1'b0, 0);
    set_cfg(1, 5, 2, 2, 9);
    run(2'd0, 1'b0, 0);
    run(2'd1, 1'b0, 0);
    run(2'd2, 1'b0, 0);

    for (int f = 0; f < 30; f++) begin
      int nb;
      set_cfg(int'($urandom_range(0, 2)), int'($urandom_range(0, 12)),
              int'($urandom_range(0, 6)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 12)));
      run(2'd0, 1'b0, 0);
      nb = int'($urandom_range(1, 5));
      for (int k = 0; k < nb; k++) begin
        run(2'd1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
        if ($urandom_range(0, 5) == 0) run(2'd0, 1'b0, int'($urandom_range(0, 2)));
      end
      run(2'd2, 1'b0, int'($urandom_range(0, 2)));
    end

    finish_run();
  end

endmodule